// File: doc/BRIEF.md
# Audio Block-Streaming DMA

This block moves PCM audio from memory to a downstream sample-rate converter in 32-byte blocks. Each block holds eight frames, and each frame is a 32-bit pair of 16-bit stereo samples. A periodic tick, running at one eighth of the output sample rate, asks for one block. When the engine is enabled it fetches the block through a valid/ready memory read port and forwards it unchanged. When it is disabled it forwards a block of zeros and does not touch memory.

The host programs a 32-byte-aligned start address and a control word, and it can read back how many blocks are left. A rising edge of the enable bit copies the programmed start and count into working registers and starts a run. A fixed number of cycles after that edge, the engine raises an interrupt so that software can queue the next buffer. The programmed registers are double-buffered: they may be rewritten during a run, and the new values are taken only at the automatic reload at the end of the run. That reload restarts the run from the programmed start address and pulses the interrupt.

A companion processor-reset request clears the whole control word.

Top module: `aud_blk_dma`

## Requirements
- R1: After reset, all four host registers read 0, `irq` and `out_valid` are 0, and no memory request is made.
- R2: Select 0 holds the start-address high half, and only bits [9:0] are writable (bits [12:0] when WIDE_ADDR=1). Select 1 holds the low half, and only bits [15:5] are writable. The start address is {high, low}.
- R3: Writing control (select 2) with bit 15 (enable) set while enable is clear copies the start address and bits [14:0] (block count) into the working address and working count. Fetches then go to the working address, which advances by 32 after each block.
- R4: With working count N>0, the N-th block output after a load or reload is followed at once by a reload from the programmed start and count. `irq` pulses for one cycle in the same cycle as that block's `out_valid`. With N=0, every block reloads and pulses `irq`.
- R5: `irq` pulses exactly IRQ_DELAY cycles after the clock edge that takes an enabling control write. No earlier pulse comes from that write.
- R6: Select 3 reads the working count minus one, or 0 when the working count is 0. Writes to select 3 are ignored.
- R7: A tick while enable is clear produces one all-zero block on the output and no memory request.
- R8: Writes to control or to the start address while enable is set do not change the run in progress. The new values are used at the next reload.
- R9: A `core_rst` pulse clears the control word to 0, so enable is clear and the count is 0. Later ticks give silent blocks.
- R10: A tick that arrives while a fetch is outstanding is held. It is served once the fetch completes, so every tick yields one block.
- R11: The eight fetched frames appear on `out_data` unchanged, with frame 0 in bits [31:0], during a one-cycle `out_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Host register write strobe |
| reg_sel | input | 2 | Register select: 0 start high, 1 start low, 2 control, 3 blocks left |
| reg_wdata | input | 16 | Host write data |
| reg_rdata | output | 16 | Read data of the selected register |
| core_rst | input | 1 | Processor-reset request; clears the control word |
| tick | input | 1 | One-cycle block request |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 16+HI_BITS | 32-byte-aligned byte address |
| mem_rsp_valid | input | 1 | Block data returned |
| mem_rsp_data | input | 256 | Eight 32-bit frames |
| out_valid | output | 1 | Block presented to the converter |
| out_data | output | 256 | Block data, zero when silent |
| irq | output | 1 | Audio interrupt pulse |

## Verification
The bench drives runs with several block counts and checks the exact sequence of fetch addresses and the cycle in which the interrupt appears. A design that stepped the address at the wrong time, or reloaded one block late, would break that sequence or move the interrupt away from the last block. It rewrites the start address and count in the middle of a run, and a design without double-buffering would jump to the new buffer early or restart at once. It also covers a zero block count, a second tick during a slow fetch, a write to the read-only count, and the processor-reset request. A wrong design would show these as a lost block, a changed readback, or a run that keeps fetching after the control word is cleared. The delayed interrupt is timed to the cycle, so an off-by-one counter shows up directly.

// File: rtl/aud_dma_pkg.sv
package aud_dma_pkg;
   localparam int SEL_W      = 2;
   localparam logic [1:0] SEL_START_HI = 2'd0;
   localparam logic [1:0] SEL_START_LO = 2'd1;
   localparam logic [1:0] SEL_CTRL     = 2'd2;
   localparam logic [1:0] SEL_LEFT     = 2'd3;
   localparam int REG_W      = 16;
   localparam int CNT_W      = 15;
   localparam int BLK_BYTES  = 32;
   localparam int ALIGN_BITS = 5;
   localparam int LO_BITS    = REG_W - ALIGN_BITS;

   typedef struct packed {
      logic             en;
      logic [CNT_W-1:0] cnt;
   } ctrl_t;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_REQ  = 2'd1,
      ST_WAIT = 2'd2
   } eng_state_t;
endpackage

// File: rtl/aud_dma_regs.sv
module aud_dma_regs
   import aud_dma_pkg::*;
#(
   parameter int HI_BITS = 10,
   localparam int AW = HI_BITS + REG_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr,
   input  logic [SEL_W-1:0] reg_sel,
   input  logic [REG_W-1:0] reg_wdata,
   output logic [REG_W-1:0] reg_rdata,
   input  logic             core_rst,
   input  logic [CNT_W-1:0] work_cnt,
   output logic [AW-1:0]    start_addr,
   output logic             en,
   output logic [CNT_W-1:0] prog_cnt,
   output logic             load,
   output logic [CNT_W-1:0] load_cnt
);
   generate
      if (HI_BITS < 1 || HI_BITS > REG_W) begin : g_bad_hi
         $error("aud_dma_regs: HI_BITS must lie in 1..16");
      end
   endgenerate

   logic [HI_BITS-1:0] start_hi;
   logic [LO_BITS-1:0] start_lo;
   ctrl_t              ctrl;
   logic               wr_ctrl;
   logic [REG_W-1:0]   blocks_left;

   assign wr_ctrl    = reg_wr && (reg_sel == SEL_CTRL);
   assign start_addr = {start_hi, start_lo, {ALIGN_BITS{1'b0}}};
   assign en         = ctrl.en;
   assign prog_cnt   = ctrl.cnt;
   assign load       = wr_ctrl && !core_rst && !ctrl.en && reg_wdata[REG_W-1];
   assign load_cnt   = reg_wdata[CNT_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_hi <= '0;
         start_lo <= '0;
         ctrl     <= '0;
      end else begin
         if (reg_wr && reg_sel == SEL_START_HI) start_hi <= reg_wdata[HI_BITS-1:0];
         if (reg_wr && reg_sel == SEL_START_LO) start_lo <= reg_wdata[REG_W-1:ALIGN_BITS];
         if (core_rst)     ctrl <= '0;
         else if (wr_ctrl) ctrl <= ctrl_t'(reg_wdata);
      end
   end

   assign blocks_left = (work_cnt == '0) ? '0 : REG_W'(work_cnt - CNT_W'(1));

   always_comb begin
      case (reg_sel)
         SEL_START_HI: reg_rdata = REG_W'(start_hi);
         SEL_START_LO: reg_rdata = {start_lo, {ALIGN_BITS{1'b0}}};
         SEL_CTRL:     reg_rdata = ctrl;
         default:      reg_rdata = blocks_left;
      endcase
   end

   // R9: a processor-reset request leaves the control word cleared
   p_ctrl_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      core_rst |=> (ctrl == '0));

   // R6: the blocks-left readback never exceeds the working count
   p_left_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_sel == SEL_LEFT) |-> (reg_rdata <= REG_W'(work_cnt)));
endmodule

// File: rtl/aud_dma_engine.sv
module aud_dma_engine
   import aud_dma_pkg::*;
#(
   parameter int AW      = 26,
   parameter int FRAMES  = 8,
   parameter int FRAME_W = 32,
   localparam int DATA_W = FRAMES * FRAME_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              en,
   input  logic              load,
   input  logic [CNT_W-1:0]  load_cnt,
   input  logic [AW-1:0]     start_addr,
   input  logic [CNT_W-1:0]  prog_cnt,
   output logic [CNT_W-1:0]  work_cnt,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic [AW-1:0]     mem_req_addr,
   input  logic              mem_rsp_valid,
   input  logic [DATA_W-1:0] mem_rsp_data,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data,
   output logic              reload
);
   generate
      if (DATA_W != 8 * BLK_BYTES) begin : g_bad_blk
         $error("aud_dma_engine: FRAMES*FRAME_W must equal one 32-byte block");
      end
      if (AW <= ALIGN_BITS) begin : g_bad_aw
         $error("aud_dma_engine: address too narrow");
      end
   endgenerate

   eng_state_t       state;
   logic [AW-1:0]    work_addr;
   logic             pend;
   logic             go;
   logic             rsp_fire;
   logic [CNT_W-1:0] nxt_cnt;

   assign go            = tick || pend;
   assign rsp_fire      = (state == ST_WAIT) && mem_rsp_valid;
   assign nxt_cnt       = (work_cnt != '0) ? work_cnt - CNT_W'(1) : '0;
   assign reload        = rsp_fire && (nxt_cnt == '0) && !load;
   assign mem_req_valid = (state == ST_REQ);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state        <= ST_IDLE;
         work_addr    <= '0;
         work_cnt     <= '0;
         pend         <= 1'b0;
         mem_req_addr <= '0;
         out_valid    <= 1'b0;
         out_data     <= '0;
      end else begin
         out_valid <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (go) begin
                  pend <= pend && tick;
                  if (en) begin
                     state        <= ST_REQ;
                     mem_req_addr <= work_addr;
                  end else begin
                     out_valid <= 1'b1;
                     out_data  <= '0;
                  end
               end
            end
            ST_REQ: begin
               if (tick) pend <= 1'b1;
               if (mem_req_ready) state <= ST_WAIT;
            end
            default: begin
               if (tick) pend <= 1'b1;
               if (mem_rsp_valid) begin
                  state     <= ST_IDLE;
                  out_valid <= 1'b1;
                  out_data  <= mem_rsp_data;
                  if (nxt_cnt == '0) begin
                     work_addr <= start_addr;
                     work_cnt  <= prog_cnt;
                  end else begin
                     work_addr <= work_addr + AW'(BLK_BYTES);
                     work_cnt  <= nxt_cnt;
                  end
               end
            end
         endcase
         if (load) begin
            work_addr <= start_addr;
            work_cnt  <= load_cnt;
         end
      end
   end

   // R3: every fetch is block aligned
   p_req_align_r3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> (mem_req_addr[ALIGN_BITS-1:0] == '0));

   // R10: a stalled request keeps its address until accepted
   p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

   // R7: a disabled tick gives a zero block in the next cycle
   p_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && go && !en) |=> (out_valid && out_data == '0 && !mem_req_valid));

   // R11: returned data is forwarded unchanged
   p_forward_r11: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_fire |=> (out_valid && out_data == $past(mem_rsp_data)));

   // R8: without a load or a completed block the run state stays put
   p_hold_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !rsp_fire) |=> ($stable(work_cnt) && $stable(work_addr)));
endmodule

// File: rtl/aud_dma_irq.sv
module aud_dma_irq #(
   parameter int DELAY = 200,
   localparam int DLY_W = $clog2(DELAY + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   input  logic reload,
   output logic irq
);
   generate
      if (DELAY < 1) begin : g_bad_dly
         $error("aud_dma_irq: DELAY must be at least 1");
      end
   endgenerate

   logic [DLY_W-1:0] cnt;
   logic             fire;

   assign fire = (cnt == DLY_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         irq <= 1'b0;
      end else begin
         if (arm)            cnt <= DLY_W'(DELAY);
         else if (cnt != '0) cnt <= cnt - DLY_W'(1);
         irq <= fire || reload;
      end
   end

   generate
      if (DELAY > 1) begin : g_chk
         // R5: arming never produces an immediate timer pulse
         p_no_early_r5: assert property (@(posedge clk) disable iff (!rst_n)
            arm |=> (!irq || $past(reload)));
      end
   endgenerate
endmodule

// File: rtl/aud_blk_dma.sv
module aud_blk_dma
   import aud_dma_pkg::*;
#(
   parameter bit WIDE_ADDR = 1'b0,
   parameter int FRAMES    = 8,
   parameter int FRAME_W   = 32,
   parameter int IRQ_DELAY = 200,
   localparam int HI_BITS  = WIDE_ADDR ? 13 : 10,
   localparam int AW       = HI_BITS + REG_W,
   localparam int DATA_W   = FRAMES * FRAME_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [1:0]        reg_sel,
   input  logic [15:0]       reg_wdata,
   output logic [15:0]       reg_rdata,
   input  logic              core_rst,
   input  logic              tick,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic [AW-1:0]     mem_req_addr,
   input  logic              mem_rsp_valid,
   input  logic [DATA_W-1:0] mem_rsp_data,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data,
   output logic              irq
);
   logic [AW-1:0]    start_addr;
   logic             en;
   logic [CNT_W-1:0] prog_cnt;
   logic             load;
   logic [CNT_W-1:0] load_cnt;
   logic [CNT_W-1:0] work_cnt;
   logic             reload;

   aud_dma_regs #(.HI_BITS(HI_BITS)) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .core_rst(core_rst),
      .work_cnt(work_cnt), .start_addr(start_addr), .en(en),
      .prog_cnt(prog_cnt), .load(load), .load_cnt(load_cnt)
   );

   aud_dma_engine #(.AW(AW), .FRAMES(FRAMES), .FRAME_W(FRAME_W)) u_engine (
      .clk(clk), .rst_n(rst_n), .tick(tick), .en(en), .load(load),
      .load_cnt(load_cnt), .start_addr(start_addr), .prog_cnt(prog_cnt),
      .work_cnt(work_cnt), .mem_req_valid(mem_req_valid),
      .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
      .out_valid(out_valid), .out_data(out_data), .reload(reload)
   );

   aud_dma_irq #(.DELAY(IRQ_DELAY)) u_irq (
      .clk(clk), .rst_n(rst_n), .arm(load), .reload(reload), .irq(irq)
   );

   // R4: the end-of-run reload interrupt coincides with the last block
   p_reload_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
      reload |=> (irq && out_valid));
endmodule

// File: tb/aud_blk_dma_bench.sv
module aud_blk_dma_bench;
   localparam int AW = 26;
   localparam int DW = 256;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_wr = 1'b0;
   logic [1:0]    reg_sel = 2'd0;
   logic [15:0]   reg_wdata = '0;
   logic [15:0]   reg_rdata;
   logic          core_rst = 1'b0;
   logic          tick = 1'b0;
   logic          mem_req_valid;
   logic          mem_req_ready = 1'b1;
   logic [AW-1:0] mem_req_addr;
   logic          mem_rsp_valid;
   logic [DW-1:0] mem_rsp_data;
   logic          out_valid;
   logic [DW-1:0] out_data;
   logic          irq;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   aud_blk_dma u_aud_blk_dma (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .core_rst(core_rst),
      .tick(tick), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_data(mem_rsp_data), .out_valid(out_valid), .out_data(out_data),
      .irq(irq)
   );

   function automatic logic [DW-1:0] blk(input logic [AW-1:0] a);
      logic [DW-1:0] d;
      for (int k = 0; k < 8; k++) d[k*32 +: 32] = {6'(k), a};
      return d;
   endfunction

   // memory model
   int            lat = 1;
   int            lat_cnt = 0;
   logic          m_busy = 1'b0;
   logic [AW-1:0] m_addr = '0;
   logic          rsp_v = 1'b0;
   logic [DW-1:0] rsp_d = '0;
   assign mem_rsp_valid = rsp_v;
   assign mem_rsp_data  = rsp_d;

   always @(posedge clk) begin
      rsp_v <= 1'b0;
      if (m_busy) begin
         if (lat_cnt == 0) begin
            rsp_v  <= 1'b1;
            rsp_d  <= blk(m_addr);
            m_busy <= 1'b0;
         end else lat_cnt <= lat_cnt - 1;
      end else if (rst_n && mem_req_valid && mem_req_ready) begin
         m_busy  <= 1'b1;
         lat_cnt <= lat;
         m_addr  <= mem_req_addr;
      end
   end

   // monitor
   int            req_count = 0;
   int            out_count = 0;
   int            irq_count = 0;
   logic [AW-1:0] last_req = '0;
   logic [DW-1:0] last_out = '0;
   logic          out_irq = 1'b0;

   always @(posedge clk) begin
      if (rst_n) begin
         if (mem_req_valid && mem_req_ready) begin
            req_count <= req_count + 1;
            last_req  <= mem_req_addr;
         end
         if (out_valid) begin
            out_count <= out_count + 1;
            last_out  <= out_data;
            out_irq   <= irq;
         end
         if (irq) irq_count <= irq_count + 1;
      end
   end

   task automatic chk(input string req, input string what,
                      input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] sel, input logic [15:0] d);
      @(negedge clk);
      reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] sel, output logic [15:0] d);
      @(negedge clk);
      reg_sel = sel;
      #1;
      d = reg_rdata;
   endtask

   task automatic wait_out(input int target);
      for (int i = 0; i < 80 && out_count < target; i++) @(negedge clk);
   endtask

   task automatic do_tick(input string req, input bit silent,
                          input logic [AW-1:0] ea, input bit eirq);
      int rq0 = req_count;
      int oc0 = out_count;
      int ic0 = irq_count;
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
      wait_out(oc0 + 1);
      @(negedge clk);
      chk(req, "block count", DW'(out_count), DW'(oc0 + 1));
      if (silent) begin
         chk(req, "no fetch", DW'(req_count), DW'(rq0));
         chk(req, "zero data", last_out, '0);
      end else begin
         chk(req, "fetch addr", DW'(last_req), DW'(ea));
         chk(req, "block data", last_out, blk(ea));
      end
      chk(req, "irq with block", DW'(out_irq), DW'(eirq));
      chk(req, "irq count", DW'(irq_count - ic0), DW'(eirq));
   endtask

   task automatic t_reset;
      logic [15:0] v;
      for (int s = 0; s < 4; s++) begin
         rd(2'(s), v);
         chk("R1", "reg after reset", DW'(v), '0);
      end
      chk("R1", "irq", DW'(irq), '0);
      chk("R1", "out_valid", DW'(out_valid), '0);
      chk("R1", "req", DW'(mem_req_valid), '0);
   endtask

   task automatic t_mask;
      logic [15:0] v;
      wr(2'd0, 16'hFFFF); rd(2'd0, v); chk("R2", "hi mask", DW'(v), DW'(16'h03FF));
      wr(2'd1, 16'hFFFF); rd(2'd1, v); chk("R2", "lo mask", DW'(v), DW'(16'hFFE0));
      wr(2'd0, 16'h0001); wr(2'd1, 16'h0117);
      rd(2'd1, v); chk("R2", "lo aligned", DW'(v), DW'(16'h0100));
   endtask

   task automatic t_silent;
      do_tick("R7", 1'b1, '0, 1'b0);
   endtask

   task automatic t_delay;
      int first = -1;
      @(negedge clk);
      reg_sel = 2'd2; reg_wdata = 16'h8002; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
      for (int n = 0; n < 210; n++) begin
         if (n > 0) @(negedge clk);
         if (irq && first < 0) first = n;
      end
      chk("R5", "delayed irq cycle", DW'(first), DW'(200));
      wr(2'd2, 16'h0000);
   endtask

   task automatic t_run;
      logic [15:0] v;
      int ic0;
      wr(2'd2, 16'h8003);
      ic0 = irq_count;
      rd(2'd3, v); chk("R6", "left after load", DW'(v), DW'(2));
      do_tick("R3", 1'b0, 26'h10100, 1'b0);
      rd(2'd3, v); chk("R6", "left after one", DW'(v), DW'(1));
      do_tick("R3", 1'b0, 26'h10120, 1'b0);
      do_tick("R4", 1'b0, 26'h10140, 1'b1);
      rd(2'd3, v); chk("R4", "left after reload", DW'(v), DW'(2));
      repeat (210) @(negedge clk);
      chk("R5", "one timer irq per enable", DW'(irq_count - ic0), DW'(2));
   endtask

   task automatic t_dbuf;
      logic [15:0] v;
      wr(2'd1, 16'h0400);
      wr(2'd2, 16'h8001);
      rd(2'd3, v); chk("R8", "run undisturbed", DW'(v), DW'(2));
      do_tick("R8", 1'b0, 26'h10100, 1'b0);
      do_tick("R8", 1'b0, 26'h10120, 1'b0);
      do_tick("R8", 1'b0, 26'h10140, 1'b1);
      rd(2'd3, v); chk("R8", "new count at reload", DW'(v), DW'(0));
      do_tick("R8", 1'b0, 26'h10400, 1'b1);
   endtask

   task automatic t_hold;
      int oc0 = out_count;
      int rq0 = req_count;
      lat = 6;
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
      wait_out(oc0 + 2);
      @(negedge clk);
      chk("R10", "both blocks", DW'(out_count - oc0), DW'(2));
      chk("R10", "both fetches", DW'(req_count - rq0), DW'(2));
      chk("R10", "second addr", DW'(last_req), DW'(26'h10400));
      lat = 1;
   endtask

   task automatic t_zero;
      logic [15:0] v;
      wr(2'd2, 16'h0000);
      wr(2'd2, 16'h8000);
      rd(2'd3, v); chk("R6", "zero count left", DW'(v), DW'(0));
      wr(2'd3, 16'h1234);
      rd(2'd3, v); chk("R6", "write ignored", DW'(v), DW'(0));
      rd(2'd2, v); chk("R3", "ctrl readback", DW'(v), DW'(16'h8000));
      do_tick("R4", 1'b0, 26'h10400, 1'b1);
      do_tick("R4", 1'b0, 26'h10400, 1'b1);
      repeat (210) @(negedge clk);
   endtask

   task automatic t_core_rst;
      logic [15:0] v;
      wr(2'd2, 16'h8005);
      @(negedge clk); core_rst = 1'b1;
      @(negedge clk); core_rst = 1'b0;
      rd(2'd2, v); chk("R9", "ctrl cleared", DW'(v), '0);
      do_tick("R9", 1'b1, '0, 1'b0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_mask();
      t_silent();
      t_delay();
      t_run();
      t_dbuf();
      t_hold();
      t_zero();
      t_core_rst();
      repeat (5) @(negedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule